// File: doc/BRIEF.md
# Multi-Queue Prioritized Transmit Scheduler

This block decides, once per clock, which of up to sixteen circular transmit queues should give up its next descriptor, and into which of seven prioritized DMA FIFO channels that descriptor goes. Each queue carries a programmable channel assignment. Several queues may share one channel, but a queue feeds only one channel. A queue asks for service when it is marked active, its read and write pointers differ, and its channel is ready.

Among the channels that have a requesting queue, the command channel (4) wins first. The data channels follow in descending order 3, 2, 1, 0, and channels 5 and 6 come last. Queues that share the winning channel take turns in round-robin order. The result is registered. It gives the chosen queue, its channel, a one-hot advance strobe for that queue's read pointer, and the incremented pointer value, which wraps at 256.

Top module: `txq_sched`

## Requirements
- R1: While `rst` is high, at the next clock edge `grant_valid` goes to 0, `adv_mask` to all zeros, and `grant_queue`, `grant_fifo` and `next_rdptr` to 0.
- R2: A queue whose read pointer equals its write pointer is empty and is never granted.
- R3: A queue whose `q_active` bit is 0 is never granted.
- R4: A queue is never granted while its assigned channel's `fifo_ready` bit is 0. A queue whose 3-bit channel field holds a value of 7 or more is unassigned and is never granted.
- R5: The channel that wins is the highest-ranked channel that has an eligible queue. The ranking from highest to lowest is 4, 3, 2, 1, 0, 5, 6.
- R6: Queues that share the winning channel are served round-robin. After reset the search starts at queue 0. After each grant, the search for that channel starts at the queue just after the last queue granted on it.
- R7: The grant is registered. Outputs sampled after the clock edge reflect the inputs present at that edge. `grant_fifo` equals the channel field of `grant_queue`. Queue q's field is `q_map[3q+2:3q]`, and queue q's pointers are `rd_ptr[8q+7:8q]` and `wr_ptr[8q+7:8q]`.
- R8: On a grant, `adv_mask` has exactly bit `grant_queue` set. `next_rdptr` equals that queue's read pointer plus 1, modulo 256, so 255 wraps to 0.
- R9: When no queue is eligible, the next edge gives `grant_valid` = 0 and `adv_mask` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_ptr | input | 128 | Per-queue 8-bit read pointers, queue q at bits 8q+7:8q |
| wr_ptr | input | 128 | Per-queue 8-bit write pointers, same layout |
| q_active | input | 16 | Per-queue enable |
| q_map | input | 48 | Per-queue 3-bit channel number, queue q at bits 3q+2:3q |
| fifo_ready | input | 7 | Per-channel ready |
| grant_valid | output | 1 | A queue was granted |
| grant_queue | output | 4 | Granted queue index |
| grant_fifo | output | 3 | Channel of the granted queue |
| adv_mask | output | 16 | One-hot read-pointer advance strobe |
| next_rdptr | output | 8 | Granted queue's read pointer plus one |

## Verification
All five outputs come from one register stage. The inputs present at a clock edge set the outputs seen just after that edge, so every result is due one cycle after its stimulus. The bench changes inputs one time unit after an edge and samples one time unit after the following edge. Round-robin results depend on earlier grants, so the bench either resets before each vector or holds the inputs steady and checks one grant per consecutive cycle. The checker keeps one-cycle copies of the inputs, so it can compare each grant with the inputs that produced it.

// File: rtl/txq_pkg.sv
package txq_pkg;
  // rank 0 is best: channel 4, then 3,2,1,0, then 5,6
  function automatic int rank_to_fifo(input int r);
    if (r == 0) return 4;
    else if (r <= 4) return 4 - r;
    else return r;
  endfunction
endpackage

// File: rtl/txq_elig.sv
module txq_elig #(
  parameter int NQ = 16,
  parameter int NF = 7,
  parameter int PW = 8,
  parameter int FW = 3
) (
  input  logic [NQ*PW-1:0] rd_ptr,
  input  logic [NQ*PW-1:0] wr_ptr,
  input  logic [NQ-1:0]    q_active,
  input  logic [NQ*FW-1:0] q_map,
  input  logic [NF-1:0]    fifo_ready,
  output logic [NF*NQ-1:0] req_by_fifo
);
  logic [NQ-1:0] live;
  for (genvar q = 0; q < NQ; q++) begin : g_q
    logic [FW-1:0] ch;
    assign ch = q_map[q*FW +: FW];
    assign live[q] = q_active[q] && (rd_ptr[q*PW +: PW] != wr_ptr[q*PW +: PW]);
    for (genvar f = 0; f < NF; f++) begin : g_f
      assign req_by_fifo[f*NQ + q] = live[q] && (ch == FW'(f)) && fifo_ready[f];
    end
  end
endmodule

// File: rtl/txq_rr.sv
module txq_rr #(
  parameter int NQ = 16,
  parameter int QW = 4
) (
  input  logic [NQ-1:0] req,
  input  logic [QW-1:0] last,
  output logic          found,
  output logic [QW-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int k = 1; k <= NQ; k++) begin
      int j;
      j = (int'(last) + k) % NQ;
      if (!found && req[j]) begin
        found = 1'b1;
        idx   = QW'(j);
      end
    end
  end
endmodule

// File: rtl/txq_prio.sv
module txq_prio #(
  parameter int NF = 7,
  parameter int FW = 3
) (
  input  logic [NF-1:0] busy,
  output logic          found,
  output logic [FW-1:0] sel
);
  import txq_pkg::*;
  always_comb begin
    found = 1'b0;
    sel   = '0;
    for (int r = 0; r < NF; r++) begin
      int f;
      f = rank_to_fifo(r);
      if (!found && f < NF && busy[f]) begin
        found = 1'b1;
        sel   = FW'(f);
      end
    end
  end
endmodule

// File: rtl/txq_sched.sv
module txq_sched #(
  parameter int NQ = 16,
  parameter int NF = 7,
  parameter int PW = 8,
  parameter int FW = 3,
  localparam int QW = $clog2(NQ)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NQ*PW-1:0] rd_ptr,
  input  logic [NQ*PW-1:0] wr_ptr,
  input  logic [NQ-1:0]    q_active,
  input  logic [NQ*FW-1:0] q_map,
  input  logic [NF-1:0]    fifo_ready,
  output logic             grant_valid,
  output logic [QW-1:0]    grant_queue,
  output logic [FW-1:0]    grant_fifo,
  output logic [NQ-1:0]    adv_mask,
  output logic [PW-1:0]    next_rdptr
);
  logic [NF*NQ-1:0] req_by_fifo;
  logic [NF-1:0]    fifo_busy;
  logic [QW-1:0]    rr_idx [NF];
  logic [QW-1:0]    last_q [NF];
  logic             win_found;
  logic [FW-1:0]    win_fifo;
  logic [QW-1:0]    win_q;

  txq_elig #(.NQ(NQ), .NF(NF), .PW(PW), .FW(FW)) u_elig (
    .rd_ptr(rd_ptr), .wr_ptr(wr_ptr), .q_active(q_active),
    .q_map(q_map), .fifo_ready(fifo_ready), .req_by_fifo(req_by_fifo)
  );

  for (genvar f = 0; f < NF; f++) begin : g_rr
    txq_rr #(.NQ(NQ), .QW(QW)) u_rr (
      .req(req_by_fifo[f*NQ +: NQ]), .last(last_q[f]),
      .found(fifo_busy[f]), .idx(rr_idx[f])
    );
  end

  txq_prio #(.NF(NF), .FW(FW)) u_prio (
    .busy(fifo_busy), .found(win_found), .sel(win_fifo)
  );

  always_comb begin
    win_q = '0;
    for (int f = 0; f < NF; f++)
      if (win_fifo == FW'(f)) win_q = rr_idx[f];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      grant_valid <= 1'b0;
      grant_queue <= '0;
      grant_fifo  <= '0;
      adv_mask    <= '0;
      next_rdptr  <= '0;
      for (int f = 0; f < NF; f++) last_q[f] <= QW'(NQ - 1);
    end else begin
      grant_valid <= win_found;
      grant_queue <= win_found ? win_q : '0;
      grant_fifo  <= win_found ? win_fifo : '0;
      adv_mask    <= win_found ? (NQ'(1) << win_q) : '0;
      next_rdptr  <= win_found ? rd_ptr[win_q*PW +: PW] + PW'(1) : '0;
      if (win_found)
        for (int f = 0; f < NF; f++)
          if (win_fifo == FW'(f)) last_q[f] <= win_q;
    end
  end
endmodule

// File: rtl/txq_sched_chk.sv
module txq_sched_chk #(
  parameter int NQ = 16,
  parameter int NF = 7,
  parameter int PW = 8,
  parameter int FW = 3,
  parameter int QW = 4
) (
  input logic             clk,
  input logic             rst,
  input logic [NQ*PW-1:0] rd_ptr,
  input logic [NQ*PW-1:0] wr_ptr,
  input logic [NQ-1:0]    q_active,
  input logic [NQ*FW-1:0] q_map,
  input logic [NF-1:0]    fifo_ready,
  input logic             grant_valid,
  input logic [QW-1:0]    grant_queue,
  input logic [FW-1:0]    grant_fifo,
  input logic [NQ-1:0]    adv_mask,
  input logic [PW-1:0]    next_rdptr
);
  logic [NQ*PW-1:0] rd_d, wr_d;
  logic [NQ-1:0]    act_d;
  logic [NQ*FW-1:0] map_d;
  logic [NF-1:0]    rdy_d;
  logic [FW-1:0]    gq_map;

  always_ff @(posedge clk) begin
    rd_d  <= rd_ptr;
    wr_d  <= wr_ptr;
    act_d <= q_active;
    map_d <= q_map;
    rdy_d <= fifo_ready;
  end

  assign gq_map = map_d[grant_queue*FW +: FW];

  p_reset_idle_r1: assert property (@(posedge clk) rst |=> (!grant_valid && adv_mask == '0));
  p_not_empty_r2: assert property (@(posedge clk) disable iff (rst)
    grant_valid |-> rd_d[grant_queue*PW +: PW] != wr_d[grant_queue*PW +: PW]);
  p_active_r3: assert property (@(posedge clk) disable iff (rst)
    grant_valid |-> act_d[grant_queue]);
  p_ready_r4: assert property (@(posedge clk) disable iff (rst)
    grant_valid |-> (int'(grant_fifo) < NF && rdy_d[grant_fifo]));
  p_fifo_match_r7: assert property (@(posedge clk) disable iff (rst)
    grant_valid |-> grant_fifo == gq_map);
  p_onehot_r8: assert property (@(posedge clk) disable iff (rst)
    grant_valid |-> ($countones(adv_mask) == 1 && adv_mask[grant_queue]));
  p_ptr_inc_r8: assert property (@(posedge clk) disable iff (rst)
    grant_valid |-> next_rdptr == rd_d[grant_queue*PW +: PW] + PW'(1));
  p_idle_mask_r9: assert property (@(posedge clk) disable iff (rst)
    !grant_valid |-> adv_mask == '0);
endmodule

bind txq_sched txq_sched_chk #(.NQ(NQ), .NF(NF), .PW(PW), .FW(FW), .QW(QW)) u_chk (
  .clk(clk), .rst(rst), .rd_ptr(rd_ptr), .wr_ptr(wr_ptr), .q_active(q_active),
  .q_map(q_map), .fifo_ready(fifo_ready), .grant_valid(grant_valid),
  .grant_queue(grant_queue), .grant_fifo(grant_fifo), .adv_mask(adv_mask),
  .next_rdptr(next_rdptr)
);

// File: tb/tb_txq_sched.sv
module tb_txq_sched;
  localparam int CLK_PERIOD = 10;
  localparam int NQ = 16, NF = 7, PW = 8, FW = 3, QW = 4;
  localparam int NV = 10;
  // {active[16], nonempty[16], ready[7], exp_valid, exp_queue[4]}
  localparam logic [43:0] VEC [NV] = '{
    {16'hFFFF, 16'hFFFF, 7'h7F, 1'b1, 4'd4},   // R5 command channel first
    {16'hFFFF, 16'hFFFF, 7'h6F, 1'b1, 4'd3},   // R4 ch4 not ready -> ch3
    {16'hFFFF, 16'h4400, 7'h7F, 1'b1, 4'd10},  // R2 q3 empty -> q10
    {16'hFFFF, 16'h0061, 7'h7F, 1'b1, 4'd0},   // R5 ch0 over ch5,6
    {16'hFFFF, 16'h0060, 7'h7F, 1'b1, 4'd5},   // R5 ch5 over ch6
    {16'hFFFF, 16'h0040, 7'h7F, 1'b1, 4'd6},   // R5 ch6 alone
    {16'h0000, 16'hFFFF, 7'h7F, 1'b0, 4'd0},   // R3 none active
    {16'hFFFF, 16'hFFFF, 7'h00, 1'b0, 4'd0},   // R9 no channel ready
    {16'h0200, 16'hFFFF, 7'h7F, 1'b1, 4'd9},   // R3 only q9 active
    {16'hFFFF, 16'h0102, 7'h7F, 1'b1, 4'd1}    // R6 q1 before q8
  };

  logic clk = 1'b0, rst = 1'b1;
  logic [NQ*PW-1:0] rd_ptr = '0, wr_ptr = '0;
  logic [NQ-1:0] q_active = '0;
  logic [NQ*FW-1:0] q_map = '0;
  logic [NF-1:0] fifo_ready = '0;
  logic grant_valid;
  logic [QW-1:0] grant_queue;
  logic [FW-1:0] grant_fifo;
  logic [NQ-1:0] adv_mask;
  logic [PW-1:0] next_rdptr;
  int total = 0, bad = 0;
  bit done = 1'b0;

  txq_sched dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int dmap(input int q);
    return (q < 7) ? q : (q - 7) % 4;
  endfunction

  task automatic chk(input string tag, input int got, input int exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%0d exp=%0d", tag, got, exp);
    end
  endtask

  task automatic setup(input logic [15:0] act, input logic [15:0] ne, input logic [6:0] rdy);
    for (int q = 0; q < NQ; q++) begin
      rd_ptr[q*PW +: PW] = PW'(q * 3);
      wr_ptr[q*PW +: PW] = ne[q] ? PW'(q * 3 + 1) : PW'(q * 3);
      q_map[q*FW +: FW]  = FW'(dmap(q));
    end
    q_active = act;
    fifo_ready = rdy;
  endtask

  task automatic do_reset();
    @(posedge clk); #1 rst = 1'b1;
    @(posedge clk); #1 rst = 1'b0;
  endtask

  task automatic chk_grant(input string tag, input int q);
    chk({tag, " valid"}, int'(grant_valid), 1);
    chk({tag, " queue"}, int'(grant_queue), q);
    chk({tag, " fifo"}, int'(grant_fifo), int'(q_map[q*FW +: FW]));
    chk({tag, " mask"}, int'(adv_mask), 1 << q);
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    setup(16'hFFFF, 16'hFFFF, 7'h7F);
    @(posedge clk); @(posedge clk); #1;
    chk("R1 valid in reset", int'(grant_valid), 0);
    chk("R1 mask in reset", int'(adv_mask), 0);
    chk("R1 ptr in reset", int'(next_rdptr), 0);

    // vector table, reset before each so round-robin state is known
    for (int i = 0; i < NV; i++) begin
      logic [43:0] v;
      v = VEC[i];
      @(posedge clk); #1 rst = 1'b1;
      setup(v[43:28], v[27:12], v[11:5]);
      @(posedge clk); #1 rst = 1'b0;
      @(posedge clk); #1;
      if (v[4]) begin
        chk_grant($sformatf("R5/R7 vec%0d", i), int'(v[3:0]));
        chk($sformatf("R8 vec%0d ptr", i), int'(next_rdptr), (int'(v[3:0]) * 3 + 1) % 256);
      end else begin
        chk($sformatf("R9 vec%0d valid", i), int'(grant_valid), 0);
        chk($sformatf("R9 vec%0d mask", i), int'(adv_mask), 0);
      end
    end

    // R6: rotation among q3,q10,q14 on channel 3
    @(posedge clk); #1 rst = 1'b1;
    setup(16'hFFFF, 16'h4408, 7'h6F);
    @(posedge clk); #1 rst = 1'b0;
    @(posedge clk); #1 chk_grant("R6 turn1", 3);
    @(posedge clk); #1 chk_grant("R6 turn2", 10);
    @(posedge clk); #1 chk_grant("R6 turn3", 14);
    @(posedge clk); #1 chk_grant("R6 turn4", 3);
    // R1: reset mid-stream
    rst = 1'b1;
    @(posedge clk); #1 chk("R1 mid reset", int'(grant_valid), 0);
    rst = 1'b0;

    // R8: wrap 255 -> 0
    @(posedge clk); #1 rst = 1'b1;
    setup(16'hFFFF, 16'h0004, 7'h7F);
    rd_ptr[2*PW +: PW] = 8'd255;
    wr_ptr[2*PW +: PW] = 8'd0;
    @(posedge clk); #1 rst = 1'b0;
    @(posedge clk); #1;
    chk_grant("R8 wrap", 2);
    chk("R8 wrap ptr", int'(next_rdptr), 0);

    // R4: unassigned channel field 7
    q_map[2*FW +: FW] = 3'd7;
    @(posedge clk); #1 chk("R4 unmapped valid", int'(grant_valid), 0);
    chk("R4 unmapped mask", int'(adv_mask), 0);

    // R7: remap q12 onto channel 4, q4 empty
    do_reset();
    setup(16'hFFFF, 16'h1001, 7'h7F);
    q_map[12*FW +: FW] = 3'd4;
    @(posedge clk); #1;
    chk_grant("R7 remap", 12);
    chk("R7 remap fifo", int'(grant_fifo), 4);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule